// File: doc/BRIEF.md
# Green-Mode Jittered Switching Oscillator

This block produces the switching-cycle start strobes for a current-mode flyback controller, timed from a fixed 50 MHz system clock. At normal load a cycle lasts 769 clocks, which is about 65 kHz. Each cycle's length is nudged by a pseudo-random offset of up to 31 clocks either way, roughly ±4 %. This spreads the switching tone over a band of frequencies. When an 8-bit feedback code (20 mV per LSB) drops below 140, the cycle is stretched linearly with the code. The cycle length is capped at 2272 clocks so that the switching rate never falls below about 22 kHz. Under a very light load the block enters a burst state in which no strobes are produced. Entry and exit use separate thresholds, so the decision has hysteresis.

Alongside each strobe the block drives a window signal that marks the part of the cycle in which the gate may be on, which is 78 % of the cycle. A burst flag reports the burst state. Three states drive the control: IDLE, RUN and BURST. The transitions are:

- IDLE to RUN when enable is high.
- RUN to BURST at a cycle boundary where the feedback code is below 80.
- BURST to RUN at a cycle boundary where the code is above 90.
- RUN or BURST to IDLE whenever enable is low.

Cycle length, window length, dither and burst state change only at a cycle boundary. The boundary is the clock on which the counter holds its last count, and the values use the feedback code present in that clock.

Top module: `green_jitter_osc`

## Requirements
- R1: While reset is asserted or enable is low, cycle_start, duty_window and burst_active are all 0. After enable rises, cycle_start is high on the first clock. That first cycle always lasts exactly 769 clocks.
- R2: cycle_start is high for exactly one clock per cycle, and consecutive strobes in RUN are spaced by the length of the cycle that began with the first of them.
- R3: For a feedback code of 140 or more, a cycle's length is 769 plus the dither offset.
- R4: The dither comes from a 7-bit register with taps x^7+x^6+1. The register is seeded to 1 by reset and by IDLE, and the next value is {r[5:0], r[6]^r[5]}. It advances once per cycle boundary. The boundary computes the next cycle's length with offset = v-31, where v = r[5:0], except that v = 63 gives an offset of 0.
- R5: For a feedback code fb below 140, the base length is 769 + (140 - fb) * 30 clocks, and the dither offset is added to it.
- R6: The cycle length, including dither, never exceeds 2272 clocks. Any larger result is replaced by 2272.
- R7: In RUN, duty_window is high on the strobe clock and on the clocks that follow it, for floor(L*78/100) clocks in total, where L is the cycle length. It is low for the rest of the cycle.
- R8: A boundary with a code below 80 moves RUN to BURST. In BURST, burst_active is 1 and cycle_start and duty_window stay 0. A code of exactly 80 does not enter burst.
- R9: A boundary with a code above 90 moves BURST to RUN. A code from 80 to 90 inclusive leaves the burst state unchanged.
- R10: A change of feedback code in the middle of a cycle affects neither the length of that cycle nor the burst state before the next boundary.
- R11: Enable going low at any time returns the block to IDLE on the next clock. The counter is then held at zero, burst_active is cleared and no strobes are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low holds the oscillator idle |
| fb_code | input | 8 | Unsigned feedback code, 20 mV per LSB |
| cycle_start | output | 1 | One-clock strobe at the start of each switching cycle |
| duty_window | output | 1 | High while the gate may be on within the current cycle |
| burst_active | output | 1 | High while pulses are suppressed in burst |

## Verification
The bench goes after four kinds of corner case:

- **Threshold edges.** The codes 140, 139, 80 and 79 sit on the edges of the stretch and burst regions. An off-by-one comparison would mis-time a cycle or enter burst at 80.
- **Length cap.** Codes 85 and 80 stretch the cycle past the 22 kHz limit. A missing or misplaced clamp would give cycles longer than 2272 clocks.
- **Mid-cycle changes.** The feedback code is changed in the middle of a cycle. A design that updates its length or burst state immediately would cut the running cycle short or suppress strobes early.
- **Hysteresis band.** The code is parked between 80 and 90 both in and out of burst. Without hysteresis the block would leave or enter burst there.

The bench also walks the dither sequence over forty cycles, so a wrong tap, seed or offset mapping shows up as a cycle of the wrong length.

// File: rtl/gjo_pkg.sv
package gjo_pkg;

    // Control states of the switching oscillator
    typedef enum logic [1:0] {
        OSC_IDLE  = 2'd0,
        OSC_RUN   = 2'd1,
        OSC_BURST = 2'd2
    } osc_state_e;

endpackage

// File: rtl/osc_dither_lfsr.sv
module osc_dither_lfsr #(
    parameter int LFSR_W     = 7,
    parameter int DITHER_MAX = 31,
    parameter int OFF_W      = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step,
    output logic signed [OFF_W-1:0] offset
);

    localparam int OFFB = $clog2(2 * DITHER_MAX + 2);
    localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1);

    logic [LFSR_W-1:0] lfsr_q;
    logic              fb_bit;
    logic [OFFB-1:0]   low_bits;

    // Feedback taps chosen per register width (maximal-length polynomials)
    generate
        if (LFSR_W == 7) begin : g_taps7
            assign fb_bit = lfsr_q[6] ^ lfsr_q[5];
        end else if (LFSR_W == 8) begin : g_taps8
            assign fb_bit = lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3];
        end else if (LFSR_W == 9) begin : g_taps9
            assign fb_bit = lfsr_q[8] ^ lfsr_q[4];
        end else begin : g_taps10
            assign fb_bit = lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_W-4];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else if (clear) begin
            lfsr_q <= SEED;
        end else if (step) begin
            lfsr_q <= {lfsr_q[LFSR_W-2:0], fb_bit};
        end
    end

    // Map the low bits onto a symmetric signed offset; the one spare code maps to zero
    assign low_bits = lfsr_q[OFFB-1:0];

    always_comb begin
        if (low_bits == OFFB'(2 * DITHER_MAX + 1)) begin
            offset = '0;
        end else begin
            offset = $signed(OFF_W'({1'b0, low_bits})) - $signed(OFF_W'(DITHER_MAX));
        end
    end

    // R4: the shift register never locks up in the all-zero state
    assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R4: the register moves on every boundary step
    assert_lfsr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> lfsr_q != $past(lfsr_q));

    // R4: the register holds between boundaries
    assert_lfsr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(lfsr_q));

endmodule

// File: rtl/osc_period_calc.sv
module osc_period_calc #(
    parameter int FB_W          = 8,
    parameter int CNT_W         = 12,
    parameter int OFF_W         = 7,
    parameter int NOM_PERIOD    = 769,
    parameter int MAX_PERIOD    = 2272,
    parameter int STRETCH_START = 140,
    parameter int STRETCH_GAIN  = 30,
    parameter int DUTY_PCT      = 78
) (
    input  logic [FB_W-1:0]         fb_code,
    input  logic signed [OFF_W-1:0] offset,
    output logic [CNT_W-1:0]        period,
    output logic [CNT_W-1:0]        duty_len
);

    int fb_i;
    int base_i;
    int total_i;
    int duty_i;

    always_comb begin
        fb_i = int'(fb_code);
        // Light load: lengthen the cycle in proportion to how far feedback has dropped
        if (fb_i < STRETCH_START) begin
            base_i = NOM_PERIOD + (STRETCH_START - fb_i) * STRETCH_GAIN;
        end else begin
            base_i = NOM_PERIOD;
        end
        total_i = base_i + int'(offset);
        // Floor frequency: never run slower than the audible-band limit
        if (total_i > MAX_PERIOD) begin
            total_i = MAX_PERIOD;
        end
        if (total_i < 2) begin
            total_i = 2;
        end
        duty_i   = (total_i * DUTY_PCT) / 100;
        period   = CNT_W'(total_i);
        duty_len = CNT_W'(duty_i);
    end

endmodule

// File: rtl/osc_cycle_fsm.sv
module osc_cycle_fsm
    import gjo_pkg::*;
#(
    parameter int FB_W        = 8,
    parameter int CNT_W       = 12,
    parameter int NOM_PERIOD  = 769,
    parameter int NOM_DUTY    = 599,
    parameter int MAX_PERIOD  = 2272,
    parameter int BURST_ENTER = 80,
    parameter int BURST_EXIT  = 90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [FB_W-1:0]  fb_code,
    input  logic [CNT_W-1:0] next_period,
    input  logic [CNT_W-1:0] next_duty,
    output logic             cycle_start,
    output logic             duty_window,
    output logic             burst_active,
    output logic             boundary,
    output logic             lfsr_clear
);

    osc_state_e       state_q;
    osc_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] duty_q;
    logic             fb_low;
    logic             fb_high;

    assign fb_low  = fb_code < FB_W'(BURST_ENTER);
    assign fb_high = fb_code > FB_W'(BURST_EXIT);

    // Last count of the running cycle
    assign boundary = (state_q != OSC_IDLE) && enable && (cnt_q == period_q - 1'b1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OSC_IDLE: begin
                if (enable) state_d = OSC_RUN;
            end
            OSC_RUN: begin
                if (!enable)                  state_d = OSC_IDLE;
                else if (boundary && fb_low)  state_d = OSC_BURST;
            end
            OSC_BURST: begin
                if (!enable)                  state_d = OSC_IDLE;
                else if (boundary && fb_high) state_d = OSC_RUN;
            end
            default: state_d = OSC_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OSC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Cycle counter and per-cycle length registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            period_q <= CNT_W'(NOM_PERIOD);
            duty_q   <= CNT_W'(NOM_DUTY);
        end else if (!enable || state_q == OSC_IDLE) begin
            cnt_q    <= '0;
            period_q <= CNT_W'(NOM_PERIOD);
            duty_q   <= CNT_W'(NOM_DUTY);
        end else if (boundary) begin
            cnt_q    <= '0;
            period_q <= next_period;
            duty_q   <= next_duty;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    // Outputs decoded from state and count
    always_comb begin
        cycle_start  = (state_q == OSC_RUN) && (cnt_q == '0);
        duty_window  = (state_q == OSC_RUN) && (cnt_q < duty_q);
        burst_active = (state_q == OSC_BURST);
        lfsr_clear   = (state_q == OSC_IDLE) || !enable;
    end

    // R11: dropping enable silences every output on the next clock
    assert_disable_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!cycle_start && !duty_window && !burst_active));

    // R8: no strobe and no on-window while bursting
    assert_burst_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active |-> (!cycle_start && !duty_window));

    // R8: a low code at a RUN boundary enters burst
    assert_burst_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OSC_RUN && boundary && fb_low) |=> burst_active);

    // R9: a code inside the hysteresis band keeps the burst flag
    assert_hysteresis_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !fb_low && !fb_high) |=> $stable(burst_active));

    // R10: the cycle length only changes at a boundary
    assert_period_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q != OSC_IDLE && !boundary) |=> (!enable || $stable(period_q)));

    // R6: no cycle ever exceeds the floor-frequency length
    assert_period_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        period_q <= CNT_W'(MAX_PERIOD));

    // R2: the strobe lasts one clock
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);

    // R7: the on-window always opens together with a strobe
    assert_window_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(duty_window) |-> cycle_start);

endmodule

// File: rtl/green_jitter_osc.sv
module green_jitter_osc #(
    parameter int FB_W          = 8,
    parameter int NOM_PERIOD    = 769,
    parameter int MAX_PERIOD    = 2272,
    parameter int DITHER_MAX    = 31,
    parameter int LFSR_W        = 7,
    parameter int BURST_ENTER   = 80,
    parameter int BURST_EXIT    = 90,
    parameter int STRETCH_START = 140,
    parameter int STRETCH_GAIN  = 30,
    parameter int DUTY_PCT      = 78
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [FB_W-1:0] fb_code,
    output logic            cycle_start,
    output logic            duty_window,
    output logic            burst_active
);

    localparam int CNT_W    = $clog2(MAX_PERIOD + 1);
    localparam int OFF_W    = $clog2(2 * DITHER_MAX + 2) + 1;
    localparam int NOM_DUTY = (NOM_PERIOD * DUTY_PCT) / 100;

    logic signed [OFF_W-1:0] offset;
    logic [CNT_W-1:0]        next_period;
    logic [CNT_W-1:0]        next_duty;
    logic                    boundary;
    logic                    lfsr_clear;

    osc_dither_lfsr #(
        .LFSR_W     (LFSR_W),
        .DITHER_MAX (DITHER_MAX),
        .OFF_W      (OFF_W)
    ) u_dither (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (lfsr_clear),
        .step   (boundary),
        .offset (offset)
    );

    osc_period_calc #(
        .FB_W          (FB_W),
        .CNT_W         (CNT_W),
        .OFF_W         (OFF_W),
        .NOM_PERIOD    (NOM_PERIOD),
        .MAX_PERIOD    (MAX_PERIOD),
        .STRETCH_START (STRETCH_START),
        .STRETCH_GAIN  (STRETCH_GAIN),
        .DUTY_PCT      (DUTY_PCT)
    ) u_calc (
        .fb_code  (fb_code),
        .offset   (offset),
        .period   (next_period),
        .duty_len (next_duty)
    );

    osc_cycle_fsm #(
        .FB_W        (FB_W),
        .CNT_W       (CNT_W),
        .NOM_PERIOD  (NOM_PERIOD),
        .NOM_DUTY    (NOM_DUTY),
        .MAX_PERIOD  (MAX_PERIOD),
        .BURST_ENTER (BURST_ENTER),
        .BURST_EXIT  (BURST_EXIT)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .fb_code      (fb_code),
        .next_period  (next_period),
        .next_duty    (next_duty),
        .cycle_start  (cycle_start),
        .duty_window  (duty_window),
        .burst_active (burst_active),
        .boundary     (boundary),
        .lfsr_clear   (lfsr_clear)
    );

endmodule

// File: tb/tb_green_jitter_osc.sv
module tb_green_jitter_osc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] fb_code = 8'd200;
    logic       cycle_start;
    logic       duty_window;
    logic       burst_active;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    green_jitter_osc dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .fb_code      (fb_code),
        .cycle_start  (cycle_start),
        .duty_window  (duty_window),
        .burst_active (burst_active)
    );

    // Vector table: feedback code, expected 2nd and 3rd cycle lengths, burst expected
    localparam int NV = 10;
    localparam int    VFB    [NV] = '{200, 140, 139, 120, 100, 91,  85,   80,   79, 0};
    localparam int    VP2    [NV] = '{739, 739, 769, 1339, 1939, 2209, 2272, 2272, 0, 0};
    localparam int    VP3    [NV] = '{740, 740, 770, 1340, 1940, 2210, 2272, 2272, 0, 0};
    localparam bit    VBURST [NV] = '{0,   0,   0,   0,    0,    0,    0,    0,    1, 1};
    localparam string VTAG   [NV] = '{"R3", "R3", "R5", "R5", "R5", "R5", "R6", "R6", "R8", "R8"};

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_strobe(input int limit, output int n, output bit got);
        n = 0;
        got = 1'b0;
        while (n < limit && !got) begin
            @(negedge clk);
            n++;
            if (cycle_start) got = 1'b1;
        end
    endtask

    // From a strobe sample: cycle length and count of on-window clocks
    task automatic measure_cycle(output int len, output int dcnt);
        bit fin;
        len  = 0;
        dcnt = duty_window ? 1 : 0;
        fin  = 1'b0;
        while (!fin && len < 3000) begin
            @(negedge clk);
            len++;
            if (cycle_start) fin = 1'b1;
            else if (duty_window) dcnt++;
        end
    endtask

    task automatic restart(input int fb);
        tick();
        enable  = 1'b0;
        fb_code = 8'(fb);
        tick();
        tick();
        enable = 1'b1;
    endtask

    function automatic int dith(input logic [6:0] r);
        int v;
        v = int'(r[5:0]);
        return (v == 63) ? 0 : v - 31;
    endfunction

    function automatic logic [6:0] dnext(input logic [6:0] r);
        return {r[5:0], r[6] ^ r[5]};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n, len, dc;
        bit got;
        logic [6:0] r;

        // R1: reset state
        repeat (4) tick();
        chk("R1", int'(cycle_start), 0, "strobe in reset");
        chk("R1", int'(duty_window), 0, "window in reset");
        chk("R1", int'(burst_active), 0, "burst in reset");
        rst_n = 1'b1;
        repeat (3) tick();
        chk("R1", int'(cycle_start), 0, "strobe while disabled");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            restart(VFB[i]);
            wait_strobe(5, n, got);
            chk("R1", n, 1, "first strobe delay after enable");
            wait_strobe(3000, n, got);
            if (VBURST[i]) begin
                chk(VTAG[i], int'(got), 0, "strobe after burst entry");
                chk(VTAG[i], int'(burst_active), 1, "burst flag");
            end else begin
                chk("R1", n, 769, "first cycle length");
                wait_strobe(3000, n, got);
                chk(VTAG[i], n, VP2[i], "second cycle length");
                chk(VTAG[i], int'(burst_active), 0, "burst flag");
                wait_strobe(3000, n, got);
                chk("R4", n, VP3[i], "third cycle length (dither stepped)");
            end
        end

        // R2: strobe is one clock wide
        restart(200);
        wait_strobe(5, n, got);
        tick();
        chk("R2", int'(cycle_start), 0, "strobe width");

        // R7: on-window length
        restart(200);
        wait_strobe(5, n, got);
        measure_cycle(len, dc);
        chk("R7", len, 769, "cycle length");
        chk("R7", dc, 599, "window in 769-clock cycle");
        measure_cycle(len, dc);
        chk("R7", dc, 576, "window in 739-clock cycle");
        restart(80);
        wait_strobe(5, n, got);
        measure_cycle(len, dc);
        measure_cycle(len, dc);
        chk("R7", len, 2272, "capped cycle length");
        chk("R7", dc, 1772, "window in 2272-clock cycle");

        // R4: dither sequence over forty cycles
        restart(200);
        wait_strobe(5, n, got);
        wait_strobe(3000, n, got);
        chk("R4", n, 769, "undithered first cycle");
        r = 7'h01;
        for (int k = 0; k < 40; k++) begin
            wait_strobe(3000, n, got);
            chk("R4", n, 769 + dith(r), "dithered cycle length");
            r = dnext(r);
        end

        // R10: mid-cycle feedback change
        restart(200);
        wait_strobe(5, n, got);
        wait_strobe(3000, n, got);
        repeat (300) tick();
        fb_code = 8'd100;
        wait_strobe(3000, n, got);
        chk("R10", n + 300, 739, "cycle length kept after mid-cycle change");
        wait_strobe(3000, n, got);
        chk("R10", n, 1940, "new length from next boundary");
        restart(200);
        wait_strobe(5, n, got);
        repeat (100) tick();
        fb_code = 8'd0;
        repeat (600) tick();
        chk("R10", int'(burst_active), 0, "no burst before boundary");
        wait_strobe(3000, n, got);
        chk("R10", int'(got), 0, "no strobe after boundary with low code");
        chk("R8", int'(burst_active), 1, "burst after boundary");

        // R9: hysteresis band
        restart(70);
        wait_strobe(5, n, got);
        wait_strobe(3000, n, got);
        chk("R8", int'(burst_active), 1, "burst at code 70");
        fb_code = 8'd85;
        wait_strobe(3000, n, got);
        chk("R9", int'(got), 0, "burst holds at code 85");
        chk("R9", int'(burst_active), 1, "burst flag holds at code 85");
        fb_code = 8'd95;
        wait_strobe(3000, n, got);
        chk("R9", int'(got), 1, "strobes resume at code 95");
        chk("R9", int'(burst_active), 0, "burst exits at code 95");
        fb_code = 8'd85;
        wait_strobe(3000, n, got);
        chk("R9", int'(got), 1, "RUN holds at code 85");
        chk("R9", int'(burst_active), 0, "no burst at code 85 from RUN");

        // R11: disable mid-run and in burst
        restart(200);
        wait_strobe(5, n, got);
        repeat (100) tick();
        enable = 1'b0;
        tick();
        chk("R11", int'(cycle_start), 0, "strobe after disable");
        chk("R11", int'(duty_window), 0, "window after disable");
        wait_strobe(1000, n, got);
        chk("R11", int'(got), 0, "no strobes while disabled");
        restart(0);
        wait_strobe(5, n, got);
        wait_strobe(3000, n, got);
        chk("R8", int'(burst_active), 1, "burst at code 0");
        enable = 1'b0;
        tick();
        chk("R11", int'(burst_active), 0, "burst cleared by disable");
        fb_code = 8'd200;
        tick();
        enable = 1'b1;
        wait_strobe(5, n, got);
        chk("R1", n, 1, "strobe on re-enable");
        wait_strobe(3000, n, got);
        chk("R1", n, 769, "first cycle after re-enable");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule